// File: doc/BRIEF.md
# Audio Clock Regeneration CTS Meter

This block sits on the transmit side of a digital display link that carries audio whose sample clock is unrelated to the link's pixel (TMDS) clock. It divides a 128x sample-rate audio clock by a programmable divisor N, which forms a measurement window. It then counts how many TMDS clock cycles fit into each window. The count is the CTS value. A sink rebuilds the audio clock as f_TMDS x N / CTS, so the count has to describe the real ratio of the two clocks.

The divider runs in the audio domain and flips a window flag at each window boundary. The flag crosses into the TMDS domain through a synchronizer, and its edges are detected there. On each detected edge, the running TMDS cycle count is captured as CTS and presented with a one-cycle valid pulse for the packet logic. The count then starts again, so no cycle falls between two windows. A count that would pass the counter's range stops at full scale and raises a sticky overflow flag.

Top module: `acr_cts_meter`

## Requirements
- R1: A measurement window lasts exactly N cycles of `audClk`, and the window flag changes once per window.
- R2: The `ctsValue` shown with each `ctsValid` pulse, except the first after reset, equals the number of `tmdsClk` rising edges since the previous pulse. The count restarts at 1 on the edge cycle, so no cycle is lost between windows.
- R3: In steady state with N and both clock periods held constant, |CTS x T_tmds - N x T_aud| <= T_tmds.
- R4: `ctsValid` is high for exactly one `tmdsClk` cycle per window. `ctsValue` changes only in a cycle where `ctsValid` is high, and it holds its value otherwise.
- R5: While N is 0, the divider is held and no `ctsValid` pulse occurs after the window in progress completes, and `ctsValue` does not change. A nonzero N resumes measurement.
- R6: A new N takes effect at the next window boundary. The window in progress when N changes completes with the old N.
- R7: The TMDS count saturates at 2^CtsWidth-1. A window that reaches it reports that full-scale value, and `ctsOverflow` goes high and stays high until reset.
- R8: While `rstN` is low, `ctsValue` is 0, `ctsValid` is 0 and `ctsOverflow` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tmdsClk | input | 1 | Link (TMDS) clock; all outputs belong to this domain |
| audClk | input | 1 | Audio clock at 128x the sample rate |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| nValue | input | NWidth (20) | Divisor N, sampled in the audio domain at window boundaries |
| ctsValue | output | CtsWidth (20) | Last measured TMDS cycle count per window |
| ctsValid | output | 1 | One-cycle pulse when a new CTS is presented |
| ctsOverflow | output | 1 | Sticky flag: a window reached full-scale count |

## Verification
A divider that miscounts shows up within one window as a CTS outside the ratio bound. A counter that drops or adds a cycle at the restart breaks the exact equality with the spacing between strobes on the very next pulse. A divisor latched at the wrong moment gives the wrong ratio on the first or second pulse after N changes. A stuck synchronizer or a lost edge shows as missing pulses, or as one CTS twice the expected size, within two windows. A narrow-counter instance drives the count into saturation to expose a flag that is not sticky or a value that wraps.

// File: rtl/acr_pkg.sv
`timescale 1ns/1ps
package acr_pkg;
  // Strobes from the TMDS-domain control to the counting datapath
  typedef struct packed {
    logic latchCts;    // capture the running count as the new CTS
    logic restartCnt;  // begin a new window count at 1
  } ctlStrobe_t;
endpackage

// File: rtl/acr_window_div.sv
`timescale 1ns/1ps
// Audio-domain divide-by-N; toggles winToggle once per N-cycle window
module acr_window_div #(
  parameter int NWidth = 20
) (
  input  logic              audClk,
  input  logic              rstN,
  input  logic [NWidth-1:0] nValue,
  output logic              winToggle
);
  localparam logic [NWidth-1:0] One = NWidth'(1);

  logic [NWidth-1:0] divCnt;
  logic [NWidth-1:0] nHeld;   // divisor in force for the current window

  always_ff @(posedge audClk or negedge rstN) begin
    if (!rstN) begin
      divCnt    <= '0;
      nHeld     <= '0;
      winToggle <= 1'b0;
    end else if (nHeld == '0) begin
      // idle: wait for a usable divisor, window starts on load
      nHeld  <= nValue;
      divCnt <= '0;
    end else if (divCnt == nHeld - One) begin
      divCnt    <= '0;
      winToggle <= ~winToggle;
      nHeld     <= nValue;    // new divisor only at a boundary
    end else begin
      divCnt <= divCnt + One;
    end
  end
endmodule

// File: rtl/acr_sync_ctl.sv
`timescale 1ns/1ps
// TMDS-domain control: synchronize window flag, detect its edges
module acr_sync_ctl
  import acr_pkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic       tmdsClk,
  input  logic       rstN,
  input  logic       winToggle,
  output ctlStrobe_t strobes
);
  logic [SyncStages-1:0] syncQ;
  logic                  edgeRef;
  logic                  winEdge;

  generate
    if (SyncStages == 1) begin : g_single
      always_ff @(posedge tmdsClk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= winToggle;
      end
    end else begin : g_chain
      always_ff @(posedge tmdsClk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SyncStages-2:0], winToggle};
      end
    end
  endgenerate

  always_ff @(posedge tmdsClk or negedge rstN) begin
    if (!rstN) edgeRef <= 1'b0;
    else       edgeRef <= syncQ[SyncStages-1];
  end

  assign winEdge = syncQ[SyncStages-1] ^ edgeRef;

  always_comb begin
    strobes            = '0;
    strobes.latchCts   = winEdge;
    strobes.restartCnt = winEdge;
  end
endmodule

// File: rtl/acr_cts_datapath.sv
`timescale 1ns/1ps
// TMDS cycle counter, CTS capture register and sticky overflow
module acr_cts_datapath
  import acr_pkg::*;
#(
  parameter int CtsWidth = 20
) (
  input  logic                tmdsClk,
  input  logic                rstN,
  input  ctlStrobe_t          strobes,
  output logic [CtsWidth-1:0] ctsValue,
  output logic                ctsValid,
  output logic                ctsOverflow
);
  localparam logic [CtsWidth-1:0] CntMax = '1;
  localparam logic [CtsWidth-1:0] CntOne = CtsWidth'(1);

  logic [CtsWidth-1:0] tmdsCount;

  always_ff @(posedge tmdsClk or negedge rstN) begin
    if (!rstN) begin
      tmdsCount <= '0;
    end else if (strobes.restartCnt) begin
      tmdsCount <= CntOne;
    end else if (tmdsCount != CntMax) begin
      tmdsCount <= tmdsCount + CntOne;
    end
  end

  always_ff @(posedge tmdsClk or negedge rstN) begin
    if (!rstN) begin
      ctsValue    <= '0;
      ctsValid    <= 1'b0;
      ctsOverflow <= 1'b0;
    end else begin
      ctsValid <= strobes.latchCts;
      if (strobes.latchCts) ctsValue <= tmdsCount;
      if (tmdsCount == CntMax) ctsOverflow <= 1'b1;
    end
  end
endmodule

// File: rtl/acr_cts_meter.sv
`timescale 1ns/1ps
module acr_cts_meter
  import acr_pkg::*;
#(
  parameter int NWidth     = 20,
  parameter int CtsWidth   = 20,
  parameter int SyncStages = 2
) (
  input  logic                tmdsClk,
  input  logic                audClk,
  input  logic                rstN,
  input  logic [NWidth-1:0]   nValue,
  output logic [CtsWidth-1:0] ctsValue,
  output logic                ctsValid,
  output logic                ctsOverflow
);
  logic       winToggle;
  ctlStrobe_t strobes;

  acr_window_div #(.NWidth(NWidth)) uDiv (
    .audClk    (audClk),
    .rstN      (rstN),
    .nValue    (nValue),
    .winToggle (winToggle)
  );

  acr_sync_ctl #(.SyncStages(SyncStages)) uCtl (
    .tmdsClk   (tmdsClk),
    .rstN      (rstN),
    .winToggle (winToggle),
    .strobes   (strobes)
  );

  acr_cts_datapath #(.CtsWidth(CtsWidth)) uDp (
    .tmdsClk     (tmdsClk),
    .rstN        (rstN),
    .strobes     (strobes),
    .ctsValue    (ctsValue),
    .ctsValid    (ctsValid),
    .ctsOverflow (ctsOverflow)
  );
endmodule

// File: rtl/acr_cts_meter_chk.sv
`timescale 1ns/1ps
module acr_cts_meter_chk #(
  parameter int NWidth   = 20,
  parameter int CtsWidth = 20
) (
  input logic                tmdsClk,
  input logic                audClk,
  input logic                rstN,
  input logic [CtsWidth-1:0] ctsValue,
  input logic                ctsValid,
  input logic                ctsOverflow,
  input logic [NWidth-1:0]   nHeld,
  input logic                winToggle,
  input logic [CtsWidth-1:0] tmdsCount
);
  // R4: valid is a single-cycle pulse
  p_single_strobe_r4: assert property (@(posedge tmdsClk) disable iff (!rstN)
    ctsValid |=> !ctsValid);

  // R4: CTS only moves together with its strobe
  p_cts_held_r4: assert property (@(posedge tmdsClk) disable iff (!rstN)
    !$stable(ctsValue) |-> ctsValid);

  // R2: new window count is already at 1 when the strobe shows
  p_restart_r2: assert property (@(posedge tmdsClk) disable iff (!rstN)
    ctsValid |-> tmdsCount == CtsWidth'(1));

  // R7: overflow flag never clears outside reset
  p_sticky_ovf_r7: assert property (@(posedge tmdsClk) disable iff (!rstN)
    ctsOverflow |=> ctsOverflow);

  // R7: a full-scale report implies the overflow flag
  p_sat_flag_r7: assert property (@(posedge tmdsClk) disable iff (!rstN)
    (ctsValid && (ctsValue == '1)) |-> ctsOverflow);

  // R5: an idle divider never flips the window flag
  p_idle_hold_r5: assert property (@(posedge audClk) disable iff (!rstN)
    (nHeld == '0) |=> $stable(winToggle));

  // R8: outputs cleared while reset is held
  always @(posedge tmdsClk) begin
    if (!rstN) begin
      p_reset_clear_r8: assert (ctsValue == '0 && !ctsValid && !ctsOverflow);
    end
  end
endmodule

bind acr_cts_meter acr_cts_meter_chk #(.NWidth(NWidth), .CtsWidth(CtsWidth)) uChk (
  .tmdsClk     (tmdsClk),
  .audClk      (audClk),
  .rstN        (rstN),
  .ctsValue    (ctsValue),
  .ctsValid    (ctsValid),
  .ctsOverflow (ctsOverflow),
  .nHeld       (uDiv.nHeld),
  .winToggle   (winToggle),
  .tmdsCount   (uDp.tmdsCount)
);

// File: tb/acr_cts_meter_tb.sv
`timescale 1ns/1ps
module acr_cts_meter_tb;
  localparam int TmdsPeriod = 8;

  logic tmdsClk = 1'b0;
  logic audClk  = 1'b0;
  logic rstN    = 1'b1;
  int   audHalf = 10;

  logic [19:0] nMain  = 20'd40;
  logic [19:0] nSmall = 20'd20;
  logic [19:0] ctsMain;
  logic        validMain, ovfMain;
  logic [9:0]  ctsSmall;
  logic        validSmall, ovfSmall;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;
  longint prevCyc = 0;
  bit  havePrev = 1'b0;
  int  strobeMain = 0;
  int  strobeSmall = 0;

  always #4 tmdsClk = ~tmdsClk;
  always begin
    #(audHalf) audClk = ~audClk;
  end

  acr_cts_meter u_dut (
    .tmdsClk(tmdsClk), .audClk(audClk), .rstN(rstN), .nValue(nMain),
    .ctsValue(ctsMain), .ctsValid(validMain), .ctsOverflow(ovfMain)
  );

  acr_cts_meter #(.CtsWidth(10)) u_dutNarrow (
    .tmdsClk(tmdsClk), .audClk(audClk), .rstN(rstN), .nValue(nSmall),
    .ctsValue(ctsSmall), .ctsValid(validSmall), .ctsOverflow(ovfSmall)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit ratioOk(input longint cts, input longint n, input longint audPer);
    longint diff = cts * TmdsPeriod - n * audPer;
    return (diff >= -TmdsPeriod) && (diff <= TmdsPeriod);
  endfunction

  always @(posedge tmdsClk) cyc++;

  // R2 monitor: each CTS equals exact edge spacing between strobes
  always @(negedge tmdsClk) begin
    if (!rstN) begin
      havePrev = 1'b0;
    end else begin
      if (validMain) begin
        if (havePrev) check(ctsMain == 20'(cyc - prevCyc), "R2", ctsMain, cyc - prevCyc);
        prevCyc  = cyc;
        havePrev = 1'b1;
        strobeMain++;
      end
      if (validSmall) strobeSmall++;
    end
  end

  task automatic waitStrobes(input bit narrow, input int n);
    int target = (narrow ? strobeSmall : strobeMain) + n;
    for (int t = 0; t < 30000; t++) begin
      @(negedge tmdsClk);
      if ((narrow ? strobeSmall : strobeMain) >= target) return;
    end
    check(1'b0, "R4 strobe timeout", narrow ? strobeSmall : strobeMain, target);
  endtask

  task automatic applyReset();
    @(negedge tmdsClk);
    rstN = 1'b0;
    repeat (4) @(negedge tmdsClk);
    check(ctsMain == 0 && !validMain && !ovfMain, "R8 main", {ovfMain, validMain, ctsMain}, 0);
    check(ctsSmall == 0 && !validSmall && !ovfSmall, "R8 narrow", {ovfSmall, validSmall, ctsSmall}, 0);
    rstN = 1'b1;
  endtask

  task automatic setN(input int n);
    @(negedge audClk);
    nMain = 20'(n);
  endtask

  initial begin
    #(TmdsPeriod * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n0;
    int holdCnt;
    logic [19:0] holdCts;
    void'($urandom(32'd7717));
    #1 rstN = 1'b0;
    applyReset();

    // R1/R3: steady windows with default N
    waitStrobes(0, 3);
    check(ratioOk(ctsMain, 40, 2 * audHalf), "R1 R3 base", ctsMain, 40 * 2 * audHalf / TmdsPeriod);

    // R3 random: N and audio period change after a strobe
    for (int k = 0; k < 6; k++) begin
      int n;
      int halves[4] = '{7, 10, 13, 17};
      n = 8 + int'($urandom % 120);
      waitStrobes(0, 1);
      audHalf = halves[$urandom % 4];
      setN(n);
      waitStrobes(0, 2);
      check(ratioOk(ctsMain, n, 2 * audHalf), "R3 random", ctsMain, n * 2 * audHalf / TmdsPeriod);
      waitStrobes(0, 1);
      check(ratioOk(ctsMain, n, 2 * audHalf), "R1 R3 repeat", ctsMain, n * 2 * audHalf / TmdsPeriod);
    end

    // R6: window in progress keeps old N, next one uses new N
    audHalf = 10;
    setN(40);
    waitStrobes(0, 3);
    n0 = 40;
    setN(100);
    waitStrobes(0, 1);
    check(ratioOk(ctsMain, n0, 20), "R6 old N", ctsMain, n0 * 20 / TmdsPeriod);
    waitStrobes(0, 1);
    check(ratioOk(ctsMain, 100, 20), "R6 new N", ctsMain, 100 * 20 / TmdsPeriod);

    // R5: N of zero stops strobes after the current window
    waitStrobes(0, 1);
    setN(0);
    waitStrobes(0, 1);
    holdCnt = strobeMain;
    holdCts = ctsMain;
    repeat (3000) @(negedge tmdsClk);
    check(strobeMain == holdCnt, "R5 no strobe", strobeMain, holdCnt);
    check(ctsMain == holdCts, "R5 cts held", ctsMain, holdCts);
    setN(1);
    waitStrobes(0, 3);
    check(ratioOk(ctsMain, 1, 20), "R1 R5 resume N=1", ctsMain, 20 / TmdsPeriod);
    setN(24);
    waitStrobes(0, 3);
    check(ratioOk(ctsMain, 24, 20), "R5 resume", ctsMain, 24 * 20 / TmdsPeriod);

    // R7: narrow counter saturates and flag sticks
    check(!ovfSmall, "R7 no early overflow", ovfSmall, 0);
    @(negedge audClk);
    nSmall = 20'd600;
    waitStrobes(1, 2);
    check(ctsSmall == 10'h3FF, "R7 saturated value", ctsSmall, 1023);
    check(ovfSmall, "R7 overflow set", ovfSmall, 1);
    check(!ovfMain, "R7 main no overflow", ovfMain, 0);
    @(negedge audClk);
    nSmall = 20'd20;
    waitStrobes(1, 3);
    check(ctsSmall < 10'h3FF, "R7 normal after", ctsSmall, 50);
    check(ovfSmall, "R7 sticky", ovfSmall, 1);

    // R8: reset clears the sticky flag and outputs
    applyReset();
    @(negedge tmdsClk);
    check(!ovfSmall, "R8 overflow cleared", ovfSmall, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule